// File: doc/BRIEF.md
# Echo Canceller Mode Control Unit

This block keeps the operating mode of an echo canceller data path. Four asynchronous mode pins are sampled at two kinds of event. One is a falling edge of an active-low load strobe. The other is the release of the active-low reset. The pins are:

- a center-clip request;
- a pass-through request;
- a coefficient-freeze request;
- a slave-role select.

From the stored mode the block drives the data path's controls: clip enable, adapt enable, slave role and a one-cycle coefficient-clear command.

The block also contains the output selection for both speech directions. In pass-through mode the raw receive and send samples go straight to their outputs. Otherwise the processed samples from the data path are used. Selection is registered only on a sample strobe, so an output word never mixes the two paths.

When the slave role is selected, the clip and freeze requests are ignored. The pass-through request still applies, so a slave chip follows the master's through setting.

Top module: `ec_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it until the first capture, the outputs are `clip_en`=0, `thru_mode`=0, `adapt_en`=1, `slave_role`=0 and `coef_clr`=0. `rout` and `sout` are 0.
- R2: A falling edge of `load_n` captures the mode pins. The captured values appear on the mode outputs after the third rising clock edge that follows the fall, and not before.
- R3: Deasserting `rst_n` captures the mode pins. The captured values appear after the third rising clock edge that follows the release.
- R4: Changes on the mode pins have no effect on any mode output unless a capture event occurs.
- R5: When `pin_slave` is captured high, `clip_en` is 0 and the freeze request is treated as low. `thru_mode` still equals the captured `pin_thru`, and `slave_role` is 1.
- R6: On a clock edge with `sample_stb` high, `rout` and `sout` load `rin` and `sin` when `thru_mode` is 1. When `thru_mode` is 0 they load `rproc` and `sproc`.
- R7: `rout` and `sout` hold their value on every clock edge where `sample_stb` is low.
- R8: `coef_clr` is high for exactly one cycle, in the same cycle in which `thru_mode` changes from 0 to 1. A capture that leaves `thru_mode` at 1 gives no pulse.
- R9: `adapt_en` is 1 only when `thru_mode` is 0 and the effective freeze request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is a capture event |
| load_n | input | 1 | Asynchronous active-low load strobe; its falling edge is a capture event |
| pin_clip | input | 1 | Center-clip request |
| pin_thru | input | 1 | Pass-through request |
| pin_freeze | input | 1 | Coefficient-freeze request |
| pin_slave | input | 1 | Role select: 0 single/master, 1 slave |
| sample_stb | input | 1 | One-cycle sample boundary strobe |
| rin | input | SAMPLE_W | Raw receive-direction sample |
| sin | input | SAMPLE_W | Raw send-direction sample |
| rproc | input | SAMPLE_W | Processed receive-direction sample |
| sproc | input | SAMPLE_W | Processed send-direction sample |
| rout | output | SAMPLE_W | Receive-direction output sample |
| sout | output | SAMPLE_W | Send-direction output sample |
| clip_en | output | 1 | Center-clip enable |
| thru_mode | output | 1 | Pass-through mode active |
| adapt_en | output | 1 | Coefficient adaptation allowed |
| slave_role | output | 1 | Slave role active |
| coef_clr | output | 1 | One-cycle coefficient-clear command |

## Verification
The bench uses the defaults: 8-bit samples, which match a companded speech byte, and a two-stage synchronizer. The two-stage synchronizer fixes the capture latency at three clock edges, so the bench can check the cycle before and the cycle of every mode update. With 8-bit random samples, the raw and processed words on each direction almost never coincide, so a wrong path choice shows up at the outputs. Random pin sets combined with the role select cover every override combination. They also cover repeated through captures, where the clear pulse must not be issued again.

// File: rtl/ec_mode_pkg.sv
package ec_mode_pkg;

    typedef struct packed {
        logic clip;
        logic thru;
        logic freeze;
        logic slave;
    } mode_t;

    localparam mode_t MODE_DEFAULT = '0;

endpackage

// File: rtl/ec_edge_sync.sv
module ec_edge_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_VAL   = 1'b1,
    parameter bit   DETECT_RISE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        end else begin
            st_d.chain[0] = async_in;
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {(STAGES + 1){RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_o = st_q.chain[LAST] & ~st_q.prev;
        end else begin : g_fall
            assign edge_o = ~st_q.chain[LAST] & st_q.prev;
        end
    endgenerate

endmodule

// File: rtl/ec_mode_regs.sv
module ec_mode_regs
    import ec_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  capture,
    input  logic  pin_clip,
    input  logic  pin_thru,
    input  logic  pin_freeze,
    input  logic  pin_slave,
    output mode_t mode_o,
    output logic  clr_o
);
    typedef struct packed {
        mode_t mode;
        logic  clr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.clr = 1'b0;
        if (capture) begin
            r_d.mode.slave  = pin_slave;
            r_d.mode.thru   = pin_thru;
            r_d.mode.clip   = pin_clip & ~pin_slave;
            r_d.mode.freeze = pin_freeze & ~pin_slave;
            r_d.clr         = pin_thru & ~r_q.mode.thru;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= MODE_DEFAULT;
            r_q.clr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o = r_q.mode;
    assign clr_o  = r_q.clr;

endmodule

// File: rtl/ec_sample_mux.sv
module ec_sample_mux #(
    parameter int SAMPLE_W = 8,
    parameter int N_DIR    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic                thru,
    input  logic [SAMPLE_W-1:0] raw_i  [N_DIR],
    input  logic [SAMPLE_W-1:0] proc_i [N_DIR],
    output logic [SAMPLE_W-1:0] out_o  [N_DIR]
);
    genvar g;
    generate
        for (g = 0; g < N_DIR; g++) begin : g_dir
            logic [SAMPLE_W-1:0] word_d, word_q;

            always_comb begin
                word_d = word_q;
                if (stb) begin
                    word_d = thru ? raw_i[g] : proc_i[g];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end

            assign out_o[g] = word_q;
        end
    endgenerate

endmodule

// File: rtl/ec_mode_ctrl.sv
module ec_mode_ctrl
    import ec_mode_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_n,
    input  logic                pin_clip,
    input  logic                pin_thru,
    input  logic                pin_freeze,
    input  logic                pin_slave,
    input  logic                sample_stb,
    input  logic [SAMPLE_W-1:0] rin,
    input  logic [SAMPLE_W-1:0] sin,
    input  logic [SAMPLE_W-1:0] rproc,
    input  logic [SAMPLE_W-1:0] sproc,
    output logic [SAMPLE_W-1:0] rout,
    output logic [SAMPLE_W-1:0] sout,
    output logic                clip_en,
    output logic                thru_mode,
    output logic                adapt_en,
    output logic                slave_role,
    output logic                coef_clr
);
    localparam int N_DIR = 2;

    logic  load_fall, rst_rise, capture;
    mode_t mode;
    logic [SAMPLE_W-1:0] raw_w  [N_DIR];
    logic [SAMPLE_W-1:0] proc_w [N_DIR];
    logic [SAMPLE_W-1:0] out_w  [N_DIR];

    ec_edge_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_VAL   (1'b1),
        .DETECT_RISE (1'b0)
    ) u_load_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (load_n),
        .edge_o   (load_fall)
    );

    ec_edge_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_VAL   (1'b0),
        .DETECT_RISE (1'b1)
    ) u_rst_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (1'b1),
        .edge_o   (rst_rise)
    );

    assign capture = load_fall | rst_rise;

    ec_mode_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .pin_clip   (pin_clip),
        .pin_thru   (pin_thru),
        .pin_freeze (pin_freeze),
        .pin_slave  (pin_slave),
        .mode_o     (mode),
        .clr_o      (coef_clr)
    );

    assign raw_w[0]  = rin;
    assign raw_w[1]  = sin;
    assign proc_w[0] = rproc;
    assign proc_w[1] = sproc;

    ec_sample_mux #(
        .SAMPLE_W (SAMPLE_W),
        .N_DIR    (N_DIR)
    ) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (sample_stb),
        .thru   (mode.thru),
        .raw_i  (raw_w),
        .proc_i (proc_w),
        .out_o  (out_w)
    );

    assign rout       = out_w[0];
    assign sout       = out_w[1];
    assign clip_en    = mode.clip;
    assign thru_mode  = mode.thru;
    assign slave_role = mode.slave;
    assign adapt_en   = ~(mode.freeze | mode.thru);

endmodule

// File: rtl/ec_mode_ctrl_chk.sv
module ec_mode_ctrl_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_stb,
    input logic [SAMPLE_W-1:0] rin,
    input logic [SAMPLE_W-1:0] sin,
    input logic [SAMPLE_W-1:0] rout,
    input logic [SAMPLE_W-1:0] sout,
    input logic                clip_en,
    input logic                thru_mode,
    input logic                adapt_en,
    input logic                slave_role,
    input logic                coef_clr
);
    // R9
    a_r9_no_adapt_in_thru: assert property (@(posedge clk) disable iff (!rst_n)
        thru_mode |-> !adapt_en);

    // R5
    a_r5_slave_no_clip: assert property (@(posedge clk) disable iff (!rst_n)
        slave_role |-> !clip_en);

    // R5
    a_r5_slave_adapts: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_role && !thru_mode) |-> adapt_en);

    // R8
    a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        coef_clr |=> !coef_clr);

    // R8
    a_r8_clr_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        coef_clr |-> (thru_mode && !$past(thru_mode)));

    // R7
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ($stable(rout) && $stable(sout)));

    // R6
    a_r6_pass_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && thru_mode) |=> (rout == $past(rin) && sout == $past(sin)));

endmodule

bind ec_mode_ctrl ec_mode_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .rin        (rin),
    .sin        (sin),
    .rout       (rout),
    .sout       (sout),
    .clip_en    (clip_en),
    .thru_mode  (thru_mode),
    .adapt_en   (adapt_en),
    .slave_role (slave_role),
    .coef_clr   (coef_clr)
);

// File: tb/ec_mode_ctrl_bench.sv
module ec_mode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n, load_n, pin_clip, pin_thru, pin_freeze, pin_slave, sample_stb;
    logic [W-1:0] rin, sin, rproc, sproc, rout, sout;
    logic clip_en, thru_mode, adapt_en, slave_role, coef_clr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int seed_dummy;

    // expected captured mode
    logic e_clip = 1'b0, e_thru = 1'b0, e_freeze = 1'b0, e_slave = 1'b0;
    logic [W-1:0] e_rout = '0, e_sout = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ec_mode_ctrl #(.SAMPLE_W(W)) u_ec_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .load_n(load_n),
        .pin_clip(pin_clip), .pin_thru(pin_thru), .pin_freeze(pin_freeze), .pin_slave(pin_slave),
        .sample_stb(sample_stb), .rin(rin), .sin(sin), .rproc(rproc), .sproc(sproc),
        .rout(rout), .sout(sout), .clip_en(clip_en), .thru_mode(thru_mode),
        .adapt_en(adapt_en), .slave_role(slave_role), .coef_clr(coef_clr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_adapt(logic f, logic t, logic s);
        return !((f & ~s) | t);
    endfunction

    task automatic check_mode(string req);
        chk({req, " clip_en"},    clip_en,    e_clip & ~e_slave);
        chk({req, " thru_mode"},  thru_mode,  e_thru);
        chk({req, " adapt_en R9"}, adapt_en,  exp_adapt(e_freeze, e_thru, e_slave));
        chk({req, " slave_role"}, slave_role, e_slave);
    endtask

    // capture through a load strobe falling edge (R2, R5, R8)
    task automatic do_load(logic c, logic t, logic f, logic s);
        logic old_thru;
        @(negedge clk);
        pin_clip = c; pin_thru = t; pin_freeze = f; pin_slave = s;
        @(negedge clk);
        load_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_mode("R2 before capture");
        chk("R8 no early clr", coef_clr, 1'b0);
        old_thru = e_thru;
        e_clip = c; e_thru = t; e_freeze = f; e_slave = s;
        @(negedge clk);
        check_mode(s ? "R5 captured" : "R2 captured");
        chk("R8 clr pulse", coef_clr, t & ~old_thru);
        @(negedge clk);
        chk("R8 clr ends", coef_clr, 1'b0);
        load_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_sample();
        @(negedge clk);
        rin = W'($urandom); sin = W'($urandom);
        rproc = W'($urandom); sproc = W'($urandom);
        sample_stb = 1'b1;
        e_rout = e_thru ? rin : rproc;
        e_sout = e_thru ? sin : sproc;
        @(negedge clk);
        sample_stb = 1'b0;
        chk("R6 rout", rout, e_rout);
        chk("R6 sout", sout, e_sout);
        rin = W'($urandom); sin = W'($urandom);
        rproc = W'($urandom); sproc = W'($urandom);
        @(negedge clk);
        chk("R7 rout hold", rout, e_rout);
        chk("R7 sout hold", sout, e_sout);
    endtask

    initial begin
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 1'b0; load_n = 1'b1; sample_stb = 1'b0;
        pin_clip = 1'b1; pin_thru = 1'b0; pin_freeze = 1'b1; pin_slave = 1'b0;
        rin = '0; sin = '0; rproc = '0; sproc = '0;
        repeat (3) @(negedge clk);
        check_mode("R1 in reset");
        chk("R1 coef_clr", coef_clr, 1'b0);
        chk("R1 rout", rout, '0);
        chk("R1 sout", sout, '0);
        rst_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_mode("R1 before capture");
        e_clip = 1'b1; e_freeze = 1'b1;
        @(negedge clk);
        check_mode("R3 reset capture");
        chk("R3 no clr", coef_clr, 1'b0);
        repeat (2) @(negedge clk);

        // directed corners
        do_sample();
        do_load(1'b0, 1'b1, 1'b0, 1'b0);   // enter thru: clear pulse
        do_sample();
        do_load(1'b1, 1'b1, 1'b1, 1'b0);   // stay thru: no pulse
        do_load(1'b1, 1'b0, 1'b1, 1'b1);   // slave overrides
        do_sample();
        do_load(1'b1, 1'b1, 1'b1, 1'b1);   // slave thru, entering again
        do_sample();
        do_load(1'b0, 1'b0, 1'b1, 1'b0);   // freeze only

        // R4: pin changes with no capture event
        @(negedge clk);
        pin_clip = 1'b1; pin_thru = 1'b1; pin_freeze = 1'b0; pin_slave = 1'b1;
        repeat (6) @(negedge clk);
        check_mode("R4 pins ignored");
        chk("R4 no clr", coef_clr, 1'b0);

        for (int i = 0; i < 80; i++) begin
            do_load(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            @(negedge clk);
            pin_clip = 1'($urandom); pin_thru = 1'($urandom);
            pin_freeze = 1'($urandom); pin_slave = 1'($urandom);
            repeat (4) @(negedge clk);
            check_mode("R4 random pins ignored");
            for (int k = 0; k < 3; k++) do_sample();
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule